// File: doc/BRIEF.md
# Pipelined Vector Sum Reducer

This block sums a vector of 64 signed 32-bit integers and returns one 32-bit total. A single adder has a loop latency of eight cycles, counting the operand read and the result write. A plain running total would have to wait eight cycles for each result before it could add the next element. The block avoids that wait by keeping eight independent running totals in flight at the same time, one in each slot of the adder pipeline.

Work is done in two phases. In the accumulate phase, elements arrive on a valid/ready stream at up to one per cycle. Each element is added to the value that leaves the pipeline exit at that moment. After all 64 elements, the pipeline therefore holds eight partial sums. Slot k holds the sum of the elements whose arrival index modulo 8 equals k. In the fold phase, the eight partial sums are copied into a small bank. The same adder then combines them by recursive doubling. On each pass, the upper half of the remaining values is added to the lower half, so the count goes 8, then 4, then 2, then 1. A pass issues only after every result of the previous pass has come back.

A caller pulses `start`, streams the elements, and waits for `done`. On the `done` cycle, `result` carries the total. The order of association is fixed and is spelled out in R5, because under non-associative arithmetic that order would decide the result.

Top module: `vec_sum_reducer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `in_ready` is 0, `done` is 0 and `result` is 0.
- R2: A `start` pulse sampled while the block is idle opens the input. In the next cycle `in_ready` is 1 and `result` reads 0.
- R3: Exactly 64 handshakes (`in_valid` and `in_ready` both high at a rising edge) are accepted per run. `in_ready` falls after the 64th and stays 0 until the next accepted `start`. Data offered during that time does not change `result`.
- R4: Cycles in which `in_valid` is low add nothing and shift no slot. The element index is the order of acceptance, whatever the gaps between handshakes.
- R5: The total is formed in this fixed order. First, P[k] = e[k] + e[k+8] + ... + e[k+56], for k = 0..7, added in ascending index. Then P[k] += P[k+4] for k < 4. Then P[k] += P[k+2] for k < 2. Finally, result = P[0] + P[1].
- R6: Arithmetic is two's complement modulo 2^32. For example, 64 copies of 0xFFFFFFFF give 0xFFFFFFC0, with no flag.
- R7: `done` is high for exactly one cycle per run. `result` already holds the final total in that cycle.
- R8: After `done`, `result` keeps its value until the next accepted `start`.
- R9: A `start` pulse while a run is in progress is ignored. The run continues, its input count is unchanged, and its total is unchanged.
- R10: Consecutive runs are independent. Each slot's first element is added to zero, so nothing from an earlier run leaks into the next total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new reduction when idle |
| in_valid | input | 1 | Element on `in_data` is offered |
| in_ready | output | 1 | Block accepts an element this cycle |
| in_data | input | 32 | Signed element value |
| done | output | 1 | One-cycle pulse: `result` is final |
| result | output | 32 | Reduced total, held until the next start |

## Verification
The checker assumes that `start` is a single-cycle pulse. It also assumes that `in_valid` carries meaning only while `in_ready` is high, so a handshake is exactly the AND of the two at an edge. Its bookkeeping of busy and idle assumes that a launch can happen only when the block is idle or in its `done` cycle. The stimulus drives every input on the falling edge and raises `start` only for one cycle. It deliberately pulses `start` in the middle of the input stream, and it keeps `in_valid` asserted after the 64th element, so that the ignore paths are actually exercised.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    localparam int unsigned ELEM_W   = 32;
    localparam int unsigned VEC_LEN  = 64;
    localparam int unsigned PIPE_LAT = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_LOAD,
        ST_ISSUE,
        ST_DRAIN
    } vsr_state_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vsr_add_pipe.sv
module vsr_add_pipe #(
    parameter int unsigned W     = vsr_pkg::ELEM_W,
    parameter int unsigned LAT   = vsr_pkg::PIPE_LAT,
    parameter int unsigned TAG_W = vsr_pkg::idx_bits(LAT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   in_vld,
    input  logic [TAG_W-1:0]       in_tag,
    input  logic [W-1:0]           op_a,
    input  logic [W-1:0]           op_b,
    output logic                   out_vld,
    output logic [TAG_W-1:0]       out_tag,
    output logic [W-1:0]           out_sum,
    output logic [LAT-1:0][W-1:0]  stage_sums
);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [W-1:0]     sum;
    } slot_t;

    slot_t stg_q [LAT];

    // Entry stage: the adder itself.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q[0] <= '0;
        end else if (en) begin
            stg_q[0].vld <= in_vld;
            stg_q[0].tag <= in_tag;
            stg_q[0].sum <= op_a + op_b;
        end
    end

    // Remaining stages model the operand read and result write latency.
    for (genvar j = 1; j < LAT; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q[j] <= '0;
            end else if (en) begin
                stg_q[j] <= stg_q[j-1];
            end
        end
    end

    for (genvar j = 0; j < LAT; j++) begin : g_view
        assign stage_sums[j] = stg_q[j].sum;
    end

    assign out_vld = stg_q[LAT-1].vld;
    assign out_tag = stg_q[LAT-1].tag;
    assign out_sum = stg_q[LAT-1].sum;

endmodule

// File: rtl/vsr_fold_bank.sv
module vsr_fold_bank #(
    parameter int unsigned W     = vsr_pkg::ELEM_W,
    parameter int unsigned LAT   = vsr_pkg::PIPE_LAT,
    parameter int unsigned TAG_W = vsr_pkg::idx_bits(LAT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [LAT-1:0][W-1:0]  load_vals,
    input  logic                   wr_en,
    input  logic [TAG_W-1:0]       wr_idx,
    input  logic [W-1:0]           wr_data,
    input  logic [TAG_W-1:0]       rd_idx,
    input  logic [TAG_W-1:0]       half,
    output logic [W-1:0]           op_lo,
    output logic [W-1:0]           op_hi
);

    logic [W-1:0] bank_q [LAT];

    // Pipeline stage j holds the slot of the (j+1)-th most recent element,
    // so slot k sits in stage LAT-1-k after the last element.
    for (genvar k = 0; k < LAT; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[k] <= '0;
            end else if (load) begin
                bank_q[k] <= load_vals[LAT-1-k];
            end else if (wr_en && (wr_idx == TAG_W'(k))) begin
                bank_q[k] <= wr_data;
            end
        end
    end

    logic [TAG_W-1:0] hi_idx;
    assign hi_idx = rd_idx + half;
    assign op_lo  = bank_q[rd_idx];
    assign op_hi  = bank_q[hi_idx];

endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl #(
    parameter int unsigned VEC_LEN = vsr_pkg::VEC_LEN,
    parameter int unsigned LAT     = vsr_pkg::PIPE_LAT,
    parameter int unsigned TAG_W   = vsr_pkg::idx_bits(LAT),
    parameter int unsigned CNT_W   = vsr_pkg::idx_bits(VEC_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    input  logic             res_vld,
    output logic             launch,
    output logic             in_ready,
    output logic             accept,
    output logic             fill_mode,
    output logic             seed_zero,
    output logic             load_bank,
    output logic             fold_mode,
    output logic             issue_vld,
    output logic [TAG_W-1:0] issue_idx,
    output logic [TAG_W-1:0] half,
    output logic             wr_en,
    output logic             final_wr,
    output logic             done
);
    import vsr_pkg::*;

    localparam logic [CNT_W-1:0] LAST_ELEM = CNT_W'(VEC_LEN - 1);
    localparam logic [CNT_W-1:0] SEED_END  = CNT_W'(LAT);
    localparam logic [TAG_W-1:0] FIRST_HALF = TAG_W'(LAT / 2);
    localparam logic [TAG_W-1:0] ONE       = TAG_W'(1);

    vsr_state_e       state_q;
    logic [CNT_W-1:0] elem_q;
    logic [TAG_W-1:0] half_q;
    logic [TAG_W-1:0] issue_q;
    logic [TAG_W-1:0] wr_q;
    logic             done_q;
    logic             pass_end;

    assign launch    = start && (state_q == ST_IDLE);
    assign in_ready  = (state_q == ST_FILL);
    assign accept    = in_ready && in_valid;
    assign fill_mode = (state_q == ST_FILL);
    assign seed_zero = (elem_q < SEED_END);
    assign load_bank = (state_q == ST_LOAD);
    assign fold_mode = (state_q == ST_ISSUE) || (state_q == ST_DRAIN);
    assign issue_vld = (state_q == ST_ISSUE);
    assign issue_idx = issue_q;
    assign half      = half_q;
    assign wr_en     = fold_mode && res_vld;
    assign pass_end  = (state_q == ST_DRAIN) && res_vld && (wr_q == half_q - ONE);
    assign final_wr  = pass_end && (half_q == ONE);
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            elem_q  <= '0;
            half_q  <= FIRST_HALF;
            issue_q <= '0;
            wr_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        elem_q  <= '0;
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (accept) begin
                        elem_q <= elem_q + 1'b1;
                        if (elem_q == LAST_ELEM) begin
                            state_q <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    half_q  <= FIRST_HALF;
                    issue_q <= '0;
                    wr_q    <= '0;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    issue_q <= issue_q + 1'b1;
                    if (issue_q == half_q - ONE) begin
                        state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (res_vld) begin
                        if (pass_end) begin
                            wr_q    <= '0;
                            issue_q <= '0;
                            if (half_q == ONE) begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else begin
                                half_q  <= half_q >> 1;
                                state_q <= ST_ISSUE;
                            end
                        end else begin
                            wr_q <= wr_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vec_sum_reducer.sv
module vec_sum_reducer #(
    parameter int unsigned W       = vsr_pkg::ELEM_W,
    parameter int unsigned VEC_LEN = vsr_pkg::VEC_LEN,
    parameter int unsigned LAT     = vsr_pkg::PIPE_LAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         done,
    output logic [W-1:0] result
);

    localparam int unsigned TAG_W = vsr_pkg::idx_bits(LAT);
    localparam int unsigned CNT_W = vsr_pkg::idx_bits(VEC_LEN + 1);

    logic                  launch, accept, fill_mode, seed_zero, load_bank;
    logic                  fold_mode, issue_vld, wr_en, final_wr;
    logic [TAG_W-1:0]      issue_idx, half;
    logic                  pipe_en, res_vld;
    logic [TAG_W-1:0]      res_tag;
    logic [W-1:0]          res_sum, op_a, op_b, op_lo, op_hi;
    logic [LAT-1:0][W-1:0] stage_sums;
    logic [W-1:0]          result_q;

    vsr_ctrl #(
        .VEC_LEN (VEC_LEN),
        .LAT     (LAT),
        .TAG_W   (TAG_W),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .res_vld   (res_vld),
        .launch    (launch),
        .in_ready  (in_ready),
        .accept    (accept),
        .fill_mode (fill_mode),
        .seed_zero (seed_zero),
        .load_bank (load_bank),
        .fold_mode (fold_mode),
        .issue_vld (issue_vld),
        .issue_idx (issue_idx),
        .half      (half),
        .wr_en     (wr_en),
        .final_wr  (final_wr),
        .done      (done)
    );

    // Accumulate phase: the pipeline only moves on a handshake, so the
    // exit value is always the running total of the incoming slot.
    assign pipe_en = accept || fold_mode;
    assign op_a    = fill_mode ? in_data : op_lo;
    assign op_b    = fill_mode ? (seed_zero ? '0 : res_sum) : op_hi;

    vsr_add_pipe #(
        .W     (W),
        .LAT   (LAT),
        .TAG_W (TAG_W)
    ) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .en         (pipe_en),
        .in_vld     (issue_vld),
        .in_tag     (issue_idx),
        .op_a       (op_a),
        .op_b       (op_b),
        .out_vld    (res_vld),
        .out_tag    (res_tag),
        .out_sum    (res_sum),
        .stage_sums (stage_sums)
    );

    vsr_fold_bank #(
        .W     (W),
        .LAT   (LAT),
        .TAG_W (TAG_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .load      (load_bank),
        .load_vals (stage_sums),
        .wr_en     (wr_en),
        .wr_idx    (res_tag),
        .wr_data   (res_sum),
        .rd_idx    (issue_idx),
        .half      (half),
        .op_lo     (op_lo),
        .op_hi     (op_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (launch) begin
            result_q <= '0;
        end else if (final_wr) begin
            result_q <= res_sum;
        end
    end

    assign result = result_q;

endmodule

// File: rtl/vsr_chk.sv
module vsr_chk #(
    parameter int unsigned W       = vsr_pkg::ELEM_W,
    parameter int unsigned VEC_LEN = vsr_pkg::VEC_LEN
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         in_valid,
    input logic         in_ready,
    input logic         done,
    input logic [W-1:0] result
);
    localparam int unsigned CNT_W = vsr_pkg::idx_bits(VEC_LEN + 1);

    logic             busy_q, hold_q;
    logic [CNT_W-1:0] acc_q;
    logic             idle;

    assign idle = !busy_q || done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            hold_q <= 1'b0;
            acc_q  <= '0;
        end else begin
            if (start && idle) begin
                busy_q <= 1'b1;
                hold_q <= 1'b0;
                acc_q  <= '0;
            end else begin
                if (done) begin
                    busy_q <= 1'b0;
                    hold_q <= 1'b1;
                end
                if (in_valid && in_ready) begin
                    acc_q <= acc_q + 1'b1;
                end
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!in_ready && !done && result == '0));

    a_r2_launch_opens: assert property (@(posedge clk) disable iff (rst)
        (start && idle) |=> (in_ready && result == '0));

    a_r3_ready_bound: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (acc_q < CNT_W'(VEC_LEN)));

    a_r3_done_after_full: assert property (@(posedge clk) disable iff (rst)
        done |-> (acc_q == CNT_W'(VEC_LEN) && !in_ready));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !start) |=> $stable(result));

    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && !idle && !in_ready) |=> !in_ready);

endmodule

bind vec_sum_reducer vsr_chk #(
    .W       (W),
    .VEC_LEN (VEC_LEN)
) u_vsr_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .result   (result)
);

// File: tb/test_vec_sum_reducer.sv
`timescale 1ns/1ps
module test_vec_sum_reducer;

    localparam int N = 64;
    localparam int S = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        done;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    logic [31:0] vec [N];

    always #2 clk = ~clk;

    vec_sum_reducer i_vec_sum_reducer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .done     (done),
        .result   (result)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_sum();
        logic [31:0] p [S];
        for (int k = 0; k < S; k++) begin
            p[k] = '0;
            for (int i = k; i < N; i += S) p[k] = p[k] + vec[i];
        end
        for (int h = S / 2; h >= 1; h = h / 2) begin
            for (int k = 0; k < h; k++) p[k] = p[k] + p[k + h];
        end
        return p[0];
    endfunction

    task automatic launch();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready == 1'b1, "R2 ready after start", {31'b0, in_ready}, 32'd1);
        check(result == 32'd0, "R2 result cleared", result, 32'd0);
    endtask

    // gap: 0 = no gaps, 1 = valid low every third cycle; poke: start mid-stream
    task automatic feed(input int gap, input bit poke);
        int i = 0;
        int cyc = 0;
        while (i < N) begin
            bit acc;
            in_valid = (gap == 0) || ((cyc % 3) != 1);
            in_data  = in_valid ? vec[i] : 32'hDEAD_BEEF;
            start    = poke && (i == 20);
            acc = in_valid && in_ready;
            @(negedge clk);
            if (acc) i++;
            cyc++;
        end
        start    = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic finish_run(input string tag);
        int n = 0;
        logic [31:0] exp = model_sum();
        // offer junk after the 64th element; it must be refused (R3)
        in_valid = 1'b1;
        in_data  = 32'h7FFF_FFFF;
        while (!done && n < 400) begin
            if (in_ready) begin
                check(1'b0, "R3 ready after 64 elements", 32'd1, 32'd0);
            end
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        check(done == 1'b1, "R7 done seen", {31'b0, done}, 32'd1);
        check(result == exp, tag, result, exp);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", {31'b0, done}, 32'd0);
        check(result == exp, "R8 result held after done", result, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!in_ready && !done && result == 0, "R1 during reset", result, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!in_ready && !done && result == 0, "R1 after reset", result, 32'd0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < N; i++) vec[i] = 32'(i * 3 + 1);
        launch();
        feed(0, 1'b0);
        check(in_ready == 1'b0, "R3 ready low after 64", {31'b0, in_ready}, 32'd0);
        finish_run("R5 ramp total");
    endtask

    task automatic t_stalls();
        for (int i = 0; i < N; i++) vec[i] = (i % 2 == 0) ? 32'(i * 1000) : -32'(i * 77);
        launch();
        feed(1, 1'b0);
        finish_run("R4 stalled stream total");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < N; i++) vec[i] = 32'hFFFF_FFFF;
        launch();
        feed(0, 1'b0);
        finish_run("R6 wrap all ones");
        check(result == 32'hFFFF_FFC0, "R6 wrap constant", result, 32'hFFFF_FFC0);
        for (int i = 0; i < N; i++) vec[i] = 32'h4000_0000 + 32'(i);
        launch();
        feed(0, 1'b0);
        finish_run("R6 wrap large positives");
    endtask

    task automatic t_busy_start();
        for (int i = 0; i < N; i++) vec[i] = 32'(i * i) ^ 32'h0000_5A5A;
        launch();
        feed(1, 1'b1);
        finish_run("R9 start during fill ignored");
        // pulse start during the fold phase
        launch();
        feed(0, 1'b0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready == 1'b0, "R9 fold start refused", {31'b0, in_ready}, 32'd0);
        finish_run("R9 start during fold ignored");
    endtask

    task automatic t_hold_and_rerun();
        logic [31:0] held = result;
        for (int c = 0; c < 12; c++) begin
            in_valid = c[0];
            in_data  = 32'(c * 999);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(result == held, "R8 result stable while idle", result, held);
        for (int i = 0; i < N; i++) vec[i] = (i < S) ? 32'(i + 1) : 32'd0;
        launch();
        feed(0, 1'b0);
        finish_run("R10 fresh run no carry-over");
        check(result == 32'd36, "R10 small total", result, 32'd36);
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_stalls();
        t_wrap();
        t_busy_start();
        t_hold_and_rerun();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule